// File: doc/BRIEF.md
# Per-Requester Error Interrupt Capture

This block gathers error responses that come back for outbound non-posted transactions and turns them into interrupts. Each error names the privilege ID of the master that issued the failed request. IDs 0 to 7 belong to processor cores 0 to 7, and ID 8 is a shared source. An accepted error sets the status bit whose index equals that ID. A routing field for each status bit steers the bit to one of eight interrupt outputs.

One capture record holds the details of the latest accepted error: its bus address, owner ID, master transaction ID and, for doorbell retry responses, the doorbell info field. Every new error overwrites this record. Software therefore reads the captured owner ID to confirm whose error it is looking at.

Software uses a small register bus. Register reads are combinational. Writes take effect at the clock edge on which `bus_we` is high. Error events are single-cycle strobes, and their effect is visible after the next clock edge.

Top module: `err_irq_capture`

## Requirements
- R1: An error event with `evt_valid` high, an ID from 0 to 8 and the block enabled sets status bit [ID]. The new value is readable one cycle later at offset 0x04, which holds the status in bits [8:0].
- R2: The routing field for ID i (i < 8) is bits [4i+3:4i] of offset 0x0C. The field for ID 8 is bits [3:0] of offset 0x10. A field value v from 0 to 7 drives `irq_out[v]`, and each output is the OR of all set status bits routed to it. After reset, ID n routes to output n for n from 0 to 7.
- R3: For IDs 0 to 7, a routing field with bit 3 set keeps that status bit off every output.
- R4: When the routing field of ID 8 has bit 3 set, status bit 8 drives all eight outputs. This is the reset value (0x8).
- R5: Each accepted error overwrites the capture record, whether or not it has been read. Offset 0x14 holds the address. Offset 0x18 holds the owner ID in [3:0], the master transaction ID in [11:4], the doorbell flag in [12] and the info field in [31:16].
- R6: The info field is captured only when the doorbell flag is set. Otherwise [31:16] of offset 0x18 reads zero.
- R7: Writing 1 to a bit of offset 0x08 clears that status bit, and 0 bits have no effect. A write to the status offset 0x04 changes nothing.
- R8: If an error for an ID and a clear of the same bit land in the same cycle, the status bit ends up set.
- R9: Bit 0 of offset 0x00 enables the block and resets to 1. While it is 0, error events change neither the status nor the capture record.
- R10: An error event with an ID above 8 is ignored. Status and capture are left unchanged.
- R11: After reset, the status, both capture registers and `irq_out` are zero.
- R12: The capture registers are read-only. Bus writes to 0x14 and 0x18 leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Single-cycle error event strobe |
| evt_addr | input | ADDR_W | Bus address of the failed transaction |
| evt_id | input | 4 | Privilege ID of the issuing master |
| evt_mstid | input | 8 | Master transaction ID |
| evt_db | input | 1 | Error is a doorbell retry response |
| evt_info | input | 16 | Doorbell info field |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 8 | Interrupt destination outputs |

## Verification
The hardest case to reach is an error and a software clear that hit the same status bit on the same clock edge. The bench drives both through one shared step task, so the event strobe and the clear write are presented together.

Broadcast of ID 8 and masking through bit 3 are both reached by reprogramming the routing fields while status bits are already set. The capture record's overwrite rule is tested with two back-to-back errors from different owners and no read in between.

// File: rtl/err_irq_capture.sv
module err_irq_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [3:0]        evt_id,
  input  logic [7:0]        evt_mstid,
  input  logic              evt_db,
  input  logic [15:0]       evt_info,
  input  logic [4:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        irq_out
);
  localparam int NID  = 9;
  localparam int NDST = 8;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_CLR = 5'h08,
                         A_RT0 = 5'h0C, A_RT1 = 5'h10, A_CAD = 5'h14, A_CIN = 5'h18;

  logic              en;
  logic [NID-1:0]    stat;
  logic [3:0]        route [NID];
  logic [ADDR_W-1:0] capt_addr;
  logic [3:0]        capt_id;
  logic [7:0]        capt_mst;
  logic              capt_db;
  logic [15:0]       capt_info;

  wire take   = evt_valid && en && (evt_id < 4'(NID));
  wire clr_wr = bus_we && (bus_addr == A_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b1;
      stat <= '0;
    end else begin
      if (bus_we && bus_addr == A_CTRL) en <= bus_wdata[0];
      for (int i = 0; i < NID; i++) begin
        if (take && evt_id == 4'(i)) stat[i] <= 1'b1;
        else if (clr_wr && bus_wdata[i]) stat[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDST; i++) route[i] <= 4'(i);
      route[NID-1] <= 4'h8;
    end else if (bus_we) begin
      if (bus_addr == A_RT0)
        for (int i = 0; i < NDST; i++) route[i] <= bus_wdata[4*i +: 4];
      if (bus_addr == A_RT1) route[NID-1] <= bus_wdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capt_addr <= '0;
      capt_id   <= '0;
      capt_mst  <= '0;
      capt_db   <= 1'b0;
      capt_info <= '0;
    end else if (take) begin
      capt_addr <= evt_addr;
      capt_id   <= evt_id;
      capt_mst  <= evt_mstid;
      capt_db   <= evt_db;
      capt_info <= evt_db ? evt_info : 16'h0;
    end
  end

  always_comb begin
    irq_out = '0;
    for (int i = 0; i < NDST; i++)
      if (stat[i] && !route[i][3]) irq_out[route[i][2:0]] = 1'b1;
    if (stat[NID-1]) begin
      if (route[NID-1][3]) irq_out = '1;
      else irq_out[route[NID-1][2:0]] = 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0] = en;
      A_STAT: bus_rdata[NID-1:0] = stat;
      A_RT0:  for (int i = 0; i < NDST; i++) bus_rdata[4*i +: 4] = route[i];
      A_RT1:  bus_rdata[3:0] = route[NID-1];
      A_CAD:  bus_rdata = 32'(capt_addr);
      A_CIN:  bus_rdata = {capt_info, 3'b000, capt_db, capt_mst, capt_id};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module err_irq_capture_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic [ADDR_W-1:0] evt_addr,
  input logic [3:0]        evt_id,
  input logic              en,
  input logic [8:0]        stat,
  input logic [7:0]        irq_out,
  input logic [ADDR_W-1:0] capt_addr,
  input logic [3:0]        capt_id
);
  AST_ERR_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && en && evt_id < 4'd9) |=> (((stat >> $past(evt_id)) & 9'd1) != 9'd0)); // R1
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 9'd0) |-> (irq_out == 8'd0)); // R2
  AST_CAPT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && en && evt_id < 4'd9) |=> (capt_id == $past(evt_id) && capt_addr == $past(evt_addr))); // R5
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && en && evt_id < 4'd9) |=> ((stat & ~$past(stat)) == 9'd0)); // R9
  AST_CAPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && en && evt_id < 4'd9) |=> ($stable(capt_addr) && $stable(capt_id))); // R12
endmodule

bind err_irq_capture err_irq_capture_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/err_irq_capture_bench.sv
module err_irq_capture_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0, evt_db = 1'b0, bus_we = 1'b0;
  logic [31:0] evt_addr = '0, bus_wdata = '0;
  logic [3:0]  evt_id = '0;
  logic [7:0]  evt_mstid = '0;
  logic [15:0] evt_info = '0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  err_irq_capture u_err_irq_capture (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    evt_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic evt(logic [3:0] id, logic [31:0] a, logic [7:0] m, logic db, logic [15:0] inf);
    evt_valid = 1'b1; evt_id = id; evt_addr = a; evt_mstid = m; evt_db = db; evt_info = inf;
    tick();
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'h00, d); chk("R9 enable reset", d, 32'h1);
    rd(5'h04, d); chk("R11 status reset", d, 0);
    rd(5'h14, d); chk("R11 capt addr reset", d, 0);
    rd(5'h18, d); chk("R11 capt info reset", d, 0);
    chk("R11 irq reset", 32'(irq_out), 0);
    rd(5'h0C, d); chk("R2 route0 reset", d, 32'h76543210);
    rd(5'h10, d); chk("R4 route1 reset", d, 32'h8);
  endtask

  task automatic t_set_route();
    logic [31:0] d;
    evt(4'd3, 32'hA000_0040, 8'h5A, 1'b0, 16'hBEEF);
    rd(5'h04, d); chk("R1 status bit3", d, 32'h008);
    chk("R2 irq core3", 32'(irq_out), 32'h08);
    rd(5'h14, d); chk("R5 capt addr", d, 32'hA000_0040);
    rd(5'h18, d); chk("R6 info dropped", d, 32'h0000_05A3);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(5'h04, 32'h1FF);
    rd(5'h04, d); chk("R7 status write ignored", d, 32'h008);
    wr(5'h08, 32'h1F7);
    rd(5'h04, d); chk("R7 zero clear bits", d, 32'h008);
    wr(5'h08, 32'h008);
    rd(5'h04, d); chk("R7 cleared", d, 0);
    chk("R7 irq after clear", 32'(irq_out), 0);
  endtask

  task automatic t_overwrite();
    logic [31:0] d;
    evt(4'd5, 32'h1234_5678, 8'h21, 1'b1, 16'h1234);
    rd(5'h18, d); chk("R6 doorbell info", d, 32'h1234_1215);
    evt(4'd2, 32'hCAFE_0000, 8'h0F, 1'b0, 16'hFFFF);
    rd(5'h14, d); chk("R5 overwrite addr", d, 32'hCAFE_0000);
    rd(5'h18, d); chk("R5 overwrite info", d, 32'h0000_00F2);
    rd(5'h04, d); chk("R1 two bits", d, 32'h024);
    chk("R2 irq two", 32'(irq_out), 32'h24);
  endtask

  task automatic t_reroute();
    logic [31:0] d;
    wr(5'h0C, 32'h76_74_37_10);
    chk("R2 rerouted OR", 32'(irq_out), 32'h80);
    wr(5'h0C, 32'h76_84_37_10);
    chk("R3 masked id5 keeps id2", 32'(irq_out), 32'h80);
    wr(5'h08, 32'h004);
    chk("R3 masked id5 no irq", 32'(irq_out), 0);
    rd(5'h04, d); chk("R3 status kept", d, 32'h020);
    wr(5'h08, 32'h1FF);
    wr(5'h0C, 32'h76543210);
  endtask

  task automatic t_id8();
    evt(4'd8, 32'h0, 8'h0, 1'b0, 16'h0);
    chk("R4 broadcast", 32'(irq_out), 32'hFF);
    wr(5'h10, 32'h3);
    chk("R2 id8 single", 32'(irq_out), 32'h08);
    wr(5'h08, 32'h100);
    chk("R7 id8 cleared", 32'(irq_out), 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    evt(4'd4, 32'h44, 8'h4, 1'b0, 16'h0);
    evt_valid = 1'b1; evt_id = 4'd4; evt_addr = 32'h88; evt_db = 1'b0;
    bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h010;
    tick();
    rd(5'h04, d); chk("R8 set wins", d, 32'h010);
    wr(5'h08, 32'h010);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(5'h00, 32'h0);
    evt(4'd6, 32'hDEAD_0000, 8'h66, 1'b1, 16'h6666);
    rd(5'h04, d); chk("R9 disabled status", d, 0);
    rd(5'h14, d); chk("R9 disabled capt", d, 32'h88);
    wr(5'h00, 32'h1);
    evt(4'd9, 32'hBAD0_0000, 8'h99, 1'b0, 16'h0);
    rd(5'h04, d); chk("R10 bad id status", d, 0);
    rd(5'h18, d); chk("R10 bad id capt", d, 32'h0000_0044);
    chk("R10 bad id irq", 32'(irq_out), 0);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    wr(5'h14, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h14, d); chk("R12 capt addr ro", d, 32'h88);
    rd(5'h18, d); chk("R12 capt info ro", d, 32'h0000_0044);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_set_route();
    t_clear();
    t_overwrite();
    t_reroute();
    t_id8();
    t_set_wins();
    t_disable();
    t_ro();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule